// File: doc/BRIEF.md
# Dual-Path Error Matrix Spreader

This unit sits behind the byte-substitution stage of a cipher datapath that computes one round per clock and carries every state twice: once as the true value and once as its bitwise complement. Each cycle, it takes both 128-bit states. Each state is a 4×4 byte matrix, and the byte at row `i`, column `j` is byte number `4*j+i`. The unit checks the complement relation byte by byte.

Any byte whose two copies disagree yields a nonzero syndrome byte. The unit folds all syndrome bytes into row and column parities. From these it forms an error matrix, reverses the bit order of every error byte, and mixes the result into both copies of the state, so that a local fault becomes a wide one within the same round. When no fault is present, the error matrix is zero and both states pass through unchanged.

A two-state alarm machine latches the first mismatch and holds it until reset.

Top module: `dp_err_spreader`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `alarm` are 0, `orig_out` is all zeros and `dual_out` is all ones.
- R2: For the byte at row i, column j (bits `8*(4*j+i)+7` down to `8*(4*j+i)` of each state), the syndrome byte is the `orig_in` byte XOR the inverted `dual_in` byte.
- R3: The error byte at (i,j) is the XOR of all four syndrome bytes of row i, XORed with the XOR of all four syndrome bytes of column j.
- R4: Before it is applied, each error byte is bit-reversed: error bit b lands on state bit 7-b of the same byte, so a syndrome of 0x01 modifies the affected bytes by 0x80.
- R5: One clock after a cycle with `in_valid` high, `out_valid` is 1, `orig_out` equals `orig_in` XOR the reversed error matrix, and `dual_out` equals `dual_in` XOR the same matrix.
- R6: If `dual_in` is the exact complement of `orig_in`, both outputs equal the inputs of the previous cycle.
- R7: A fault in one byte of `orig_in` leaves 7 bytes of `orig_out` wrong: the faulty byte and the other bytes of its row and column. All other bytes are untouched.
- R8: The alarm machine has two states, WATCH and TRIPPED. WATCH moves to TRIPPED on a valid cycle with any nonzero syndrome byte, and `alarm` rises with the same edge that updates the outputs. TRIPPED stays TRIPPED until reset, and `alarm` is 1 exactly in TRIPPED.
- R9: A fault that is applied as matching complemented values to both copies gives a zero error matrix. Such a fault raises no alarm and reaches `orig_out` unspread.
- R10: When `in_valid` is low, the inputs are ignored: `out_valid` is 0 and both output states hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Both input states are valid this cycle |
| orig_in | input | 128 | True-value state after substitution |
| dual_in | input | 128 | Complemented state after substitution |
| out_valid | output | 1 | Output states updated by the last edge |
| orig_out | output | 128 | True-value state with the error matrix mixed in |
| dual_out | output | 128 | Complemented state with the error matrix mixed in |
| alarm | output | 1 | Sticky fault indication |

## Verification
Every result, meaning both output states, `out_valid` and the alarm, is due exactly one clock edge after the input cycle that produced it. The driver applies inputs on falling edges and places the expected outputs in a queue. The monitor samples 1 ns after each rising edge and pops one entry for each cycle in which `out_valid` is high, so every comparison falls in the cycle where the register has just loaded. Targeted checks on bit reversal, the spread count and the paired-fault case read the outputs on the falling edge after the capturing edge. Hold checks read the outputs after several idle cycles.

// File: rtl/dp_err_pkg.sv
package dp_err_pkg;

    typedef enum logic [0:0] {
        ALM_WATCH   = 1'b0,
        ALM_TRIPPED = 1'b1
    } alm_state_e;

    // Column-major placement of matrix bytes inside a flat state vector
    function automatic int cell_index(input int row, input int col, input int rows);
        return col * rows + row;
    endfunction

endpackage

// File: rtl/dp_err_syndrome.sv
module dp_err_syndrome
    import dp_err_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int BYTE_W = 8
) (
    input  logic [ROWS*COLS*BYTE_W-1:0] orig_st,
    input  logic [ROWS*COLS*BYTE_W-1:0] dual_st,
    output logic [ROWS*COLS*BYTE_W-1:0] err_mat,
    output logic                        mismatch
);
    localparam int CELLS = ROWS * COLS;

    logic [CELLS-1:0][BYTE_W-1:0] synd;
    logic [ROWS-1:0][BYTE_W-1:0]  row_par;
    logic [COLS-1:0][BYTE_W-1:0]  col_par;

    for (genvar k = 0; k < CELLS; k++) begin : g_synd
        assign synd[k] = orig_st[k*BYTE_W +: BYTE_W] ^ ~dual_st[k*BYTE_W +: BYTE_W];
    end

    always_comb begin
        row_par = '0;
        col_par = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                row_par[r] = row_par[r] ^ synd[cell_index(r, c, ROWS)];
                col_par[c] = col_par[c] ^ synd[cell_index(r, c, ROWS)];
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign err_mat[(c*ROWS+r)*BYTE_W +: BYTE_W] = row_par[r] ^ col_par[c];
        end
    end

    assign mismatch = |synd;

endmodule

// File: rtl/dp_err_fold.sv
module dp_err_fold #(
    parameter int CELLS  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [CELLS*BYTE_W-1:0] orig_st,
    input  logic [CELLS*BYTE_W-1:0] dual_st,
    input  logic [CELLS*BYTE_W-1:0] err_mat,
    output logic [CELLS*BYTE_W-1:0] orig_nx,
    output logic [CELLS*BYTE_W-1:0] dual_nx
);
    logic [CELLS*BYTE_W-1:0] err_rev;

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            assign err_rev[k*BYTE_W + b] = err_mat[k*BYTE_W + (BYTE_W-1-b)];
        end
    end

    // True path takes the mask directly; complemented path takes the
    // complemented mask through XNOR, which keeps the pair aligned.
    assign orig_nx = orig_st ^ err_rev;
    assign dual_nx = dual_st ~^ ~err_rev;

endmodule

// File: rtl/dp_err_spreader.sv
module dp_err_spreader
    import dp_err_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [ROWS*COLS*BYTE_W-1:0] orig_in,
    input  logic [ROWS*COLS*BYTE_W-1:0] dual_in,
    output logic                        out_valid,
    output logic [ROWS*COLS*BYTE_W-1:0] orig_out,
    output logic [ROWS*COLS*BYTE_W-1:0] dual_out,
    output logic                        alarm
);
    localparam int CELLS   = ROWS * COLS;
    localparam int STATE_W = CELLS * BYTE_W;

    logic [STATE_W-1:0] err_mat;
    logic [STATE_W-1:0] orig_nx;
    logic [STATE_W-1:0] dual_nx;
    logic               mismatch;
    alm_state_e         alm_q;
    alm_state_e         alm_d;

    dp_err_syndrome #(.ROWS(ROWS), .COLS(COLS), .BYTE_W(BYTE_W)) syn_i (
        .orig_st  (orig_in),
        .dual_st  (dual_in),
        .err_mat  (err_mat),
        .mismatch (mismatch)
    );

    dp_err_fold #(.CELLS(CELLS), .BYTE_W(BYTE_W)) fold_i (
        .orig_st (orig_in),
        .dual_st (dual_in),
        .err_mat (err_mat),
        .orig_nx (orig_nx),
        .dual_nx (dual_nx)
    );

    // Alarm machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alm_q <= ALM_WATCH;
        else        alm_q <= alm_d;
    end

    // Alarm machine: transitions
    always_comb begin
        alm_d = alm_q;
        unique case (alm_q)
            ALM_WATCH:   if (in_valid && mismatch) alm_d = ALM_TRIPPED;
            ALM_TRIPPED: alm_d = ALM_TRIPPED;
        endcase
    end

    // Alarm machine: outputs
    always_comb begin
        alarm = (alm_q == ALM_TRIPPED);
    end

    // State registers for both paths
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            orig_out  <= '0;
            dual_out  <= '1;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                orig_out <= orig_nx;
                dual_out <= dual_nx;
            end
        end
    end

endmodule

module dp_err_spreader_chk #(
    parameter int STATE_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [STATE_W-1:0] orig_in,
    input logic [STATE_W-1:0] dual_in,
    input logic               out_valid,
    input logic [STATE_W-1:0] orig_out,
    input logic [STATE_W-1:0] dual_out,
    input logic               alarm
);
    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_pair_syndrome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((orig_out ^ dual_out) == $past(orig_in ^ dual_in)));

    assert_clean_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (orig_in == ~dual_in)) |=>
            (orig_out == $past(orig_in) && dual_out == $past(dual_in)));

    assert_alarm_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (orig_in != ~dual_in)) |=> alarm);

    assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);

    assert_alarm_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(in_valid && (orig_in != ~dual_in)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(orig_out) && $stable(dual_out)));

endmodule

bind dp_err_spreader dp_err_spreader_chk #(.STATE_W(STATE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .orig_in   (orig_in),
    .dual_in   (dual_in),
    .out_valid (out_valid),
    .orig_out  (orig_out),
    .dual_out  (dual_out),
    .alarm     (alarm)
);

// File: tb/dp_err_spreader_tb_top.sv
`timescale 1ns/1ps
module dp_err_spreader_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] orig_in = '0;
    logic [127:0] dual_in = '0;
    logic         out_valid;
    logic [127:0] orig_out;
    logic [127:0] dual_out;
    logic         alarm;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit model_alarm = 1'b0;

    logic [127:0] q_orig[$];
    logic [127:0] q_dual[$];
    logic         q_alarm[$];
    string        q_tag[$];

    always #10 clk = ~clk;

    dp_err_spreader dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .orig_in(orig_in), .dual_in(dual_in),
        .out_valid(out_valid), .orig_out(orig_out), .dual_out(dual_out),
        .alarm(alarm)
    );

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [7:0] get_b(logic [127:0] v, int row, int col);
        return v[8*(4*col+row) +: 8];
    endfunction

    function automatic logic [127:0] flip_b(logic [127:0] v, int row, int col, logic [7:0] m);
        logic [127:0] r = v;
        r[8*(4*col+row) +: 8] = v[8*(4*col+row) +: 8] ^ m;
        return r;
    endfunction

    // Reference model built from R2, R3, R4, R5
    task automatic ref_model(input logic [127:0] o, input logic [127:0] d,
                             output logic [127:0] eo, output logic [127:0] ed,
                             output bit flag);
        logic [7:0] s[4][4];
        logic [7:0] rs[4];
        logic [7:0] cs[4];
        logic [7:0] e;
        logic [7:0] rv;
        flag = 1'b0;
        eo = o;
        ed = d;
        for (int i = 0; i < 4; i++) begin rs[i] = '0; cs[i] = '0; end
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                s[i][j] = get_b(o, i, j) ^ ~get_b(d, i, j);
                if (s[i][j] != 0) flag = 1'b1;
                rs[i] ^= s[i][j];
                cs[j] ^= s[i][j];
            end
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                e = rs[i] ^ cs[j];
                for (int b = 0; b < 8; b++) rv[7-b] = e[b];
                eo = flip_b(eo, i, j, rv);
                ed = flip_b(ed, i, j, rv);
            end
    endtask

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [127:0] o, input logic [127:0] d, input string tag);
        logic [127:0] eo;
        logic [127:0] ed;
        bit f;
        @(negedge clk);
        in_valid = 1'b1;
        orig_in = o;
        dual_in = d;
        ref_model(o, d, eo, ed, f);
        model_alarm = model_alarm | f;
        q_orig.push_back(eo);
        q_dual.push_back(ed);
        q_alarm.push_back(model_alarm);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        orig_in = rnd128();
        dual_in = rnd128();
    endtask

    function automatic int count_diff(logic [127:0] a, logic [127:0] b);
        int n = 0;
        for (int k = 0; k < 16; k++) if (a[8*k +: 8] != b[8*k +: 8]) n++;
        return n;
    endfunction

    // Monitor: one expected item per cycle with out_valid high
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            if (q_orig.size() == 0) begin
                check(1'b0, "R5 unexpected out_valid", {127'b0, out_valid}, 128'd0);
            end else begin
                logic [127:0] eo;
                logic [127:0] ed;
                logic         ea;
                string        t;
                eo = q_orig.pop_front();
                ed = q_dual.pop_front();
                ea = q_alarm.pop_front();
                t  = q_tag.pop_front();
                check(orig_out == eo, {t, " orig_out R5"}, orig_out, eo);
                check(dual_out == ed, {t, " dual_out R5"}, dual_out, ed);
                check(alarm == ea, {t, " alarm R8"}, {127'b0, alarm}, {127'b0, ea});
            end
        end
    end

    initial begin
        logic [127:0] base;
        logic [127:0] fo;
        logic [127:0] held;
        // R1: reset values
        repeat (2) @(negedge clk);
        check(out_valid == 0 && alarm == 0, "R1 flags in reset",
              {126'b0, out_valid, alarm}, 128'd0);
        check(orig_out == '0 && dual_out == '1, "R1 states in reset",
              orig_out ^ ~dual_out, 128'd0);
        rst_n = 1'b1;

        // R6: clean vectors back to back
        for (int n = 0; n < 6; n++) begin
            base = rnd128();
            drive(base, ~base, "R6 clean");
        end
        idle();
        check(alarm == 0, "R6 no alarm after clean data", {127'b0, alarm}, 128'd0);

        // R9: paired complemented fault on byte (1,2)
        base = rnd128();
        fo = flip_b(base, 1, 2, 8'h3C);
        drive(fo, ~fo, "R9 paired fault");
        idle();
        check(alarm == 0, "R9 paired fault alarm", {127'b0, alarm}, 128'd0);
        check(count_diff(orig_out, base) == 1, "R9 paired fault stays local",
              orig_out, fo);

        // R4, R2: single bit 0 fault in byte (0,0), syndrome 0x01 -> mask 0x80
        base = rnd128();
        fo = flip_b(base, 0, 0, 8'h01);
        drive(fo, ~base, "R4 single bit");
        idle();
        check(get_b(orig_out, 0, 1) == (get_b(base, 0, 1) ^ 8'h80), "R4 row neighbour reversed",
              {120'b0, get_b(orig_out, 0, 1)}, {120'b0, get_b(base, 0, 1) ^ 8'h80});
        check(get_b(orig_out, 3, 0) == (get_b(base, 3, 0) ^ 8'h80), "R4 column neighbour reversed",
              {120'b0, get_b(orig_out, 3, 0)}, {120'b0, get_b(base, 3, 0) ^ 8'h80});
        check(get_b(orig_out, 2, 2) == get_b(base, 2, 2), "R3 off-cross byte untouched",
              {120'b0, get_b(orig_out, 2, 2)}, {120'b0, get_b(base, 2, 2)});
        check(alarm == 1, "R8 alarm rises with outputs", {127'b0, alarm}, 128'd1);

        // R7: single byte fault in byte (2,3)
        base = rnd128();
        fo = flip_b(base, 2, 3, 8'h5A);
        drive(fo, ~base, "R7 single byte");
        idle();
        check(count_diff(orig_out, base) == 7, "R7 spread count",
              count_diff(orig_out, base), 128'd7);
        check(get_b(orig_out, 2, 3) == get_b(fo, 2, 3), "R3 faulty byte keeps zero error",
              {120'b0, get_b(orig_out, 2, 3)}, {120'b0, get_b(fo, 2, 3)});

        // R5, R3: multi-byte faults on either path, back to back
        for (int n = 0; n < 5; n++) begin
            base = rnd128();
            drive(flip_b(base, n % 4, (n + 1) % 4, 8'(n + 3)),
                  flip_b(~base, (n + 2) % 4, n % 4, 8'h91), "R3 multi fault");
        end

        // R10: held outputs while in_valid is low
        idle();
        held = orig_out;
        repeat (4) idle();
        check(orig_out == held && out_valid == 0, "R10 outputs hold while idle",
              orig_out, held);
        check(alarm == 1, "R8 alarm stays set", {127'b0, alarm}, 128'd1);

        // R8: only reset clears the alarm
        @(negedge clk);
        rst_n = 1'b0;
        model_alarm = 1'b0;
        @(negedge clk);
        check(alarm == 0 && out_valid == 0, "R1 R8 reset clears alarm",
              {126'b0, alarm, out_valid}, 128'd0);
        rst_n = 1'b1;
        base = rnd128();
        drive(base, ~base, "R6 clean after reset");
        idle();
        idle();
        check(q_orig.size() == 0, "R5 all results delivered", q_orig.size(), 128'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule